// File: doc/BRIEF.md
# Interleaving Memory Address Range Decoder

This block sits in a memory hierarchy between an incoming request stream and a set of downstream target ports. It holds a bank of independent range decoders. Each one claims host physical addresses that fall inside its programmed window. In routing mode it picks a single target port, or it spreads consecutive granules of the window across two or four ports. In endpoint mode it routes nothing. It turns the matched address into a dense device-local address instead.

The block is built for cascaded interleave. A decoder can be told how many selection bits a higher level has already used. It then takes its own selection bits above those. An endpoint decoder squeezes out the selection bits of every level, so the device sees a contiguous space. Software programs each decoder through a simple write port and makes it live with a commit bit. Each lookup returns one registered result behind a valid/ready handshake.

Top module: `ilv_addr_decoder`

## Requirements
- R1: Out of reset, resValid is 0 and reqReady is 1, and no decoder is committed.
- R2: A decoder claims an address A only when base <= A < base + size. An address just below base, or equal to base + size, is not claimed by that decoder.
- R3: A committed routing decoder with ways code 0 returns target-list entry 0 (cfgData bits [1:0] of field 3) on resPort, and passes the host address through unchanged on resAddr.
- R4: With ways code w (control bits [1:0]; 1 means 2 ways, 2 means 4 ways; 3 is reserved) and a granule of 4 KiB (control bit 2 = 0) or 8 KiB (bit 2 = 1), the way index is (A >> (12 + bit2 + skip)) mod 2^w. resPort is target-list entry number way, and entry k sits at field-3 bits [2k+1:2k].
- R5: The skip count (control bits [4:3]) moves the way-selection bits up past the bits that upstream levels have already used.
- R6: In endpoint mode (control bit 5), resPort is 0. resAddr is the device base (field 4) plus the offset A - base, with the skip + w bits just above the granule removed, and the granule bits kept.
- R7: When several committed decoders claim an address, the lowest-numbered one supplies the result.
- R8: A decoder with a clear commit bit (control bit 8) never claims an address.
- R9: Writes to a committed decoder are ignored. The one exception is a control-field write with bit 8 clear, which clears only the commit bit.
- R10: A result appears on the clock edge after the request is accepted. reqReady is low while resValid is high and resReady is low, and the result then holds stable.
- R11: An address that no committed decoder claims gives resMiss = 1, resPort = 0 and resAddr = 0.
- R12: The write port selects a field with cfgField: 0 is base, 1 is size, 2 is control, 3 is the target list, 4 is the device base. A write takes effect on the next edge, and a lookup in the same cycle still sees the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request address is valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Host physical address to decode |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDecSel | input | DEC_IDX_W | Decoder being written |
| cfgField | input | 3 | Field being written |
| cfgData | input | ADDR_W | Write data |
| resValid | output | 1 | Lookup result is valid |
| resReady | input | 1 | Downstream takes the result |
| resPort | output | PORT_W | Selected target port |
| resAddr | output | ADDR_W | Host address (routing) or device address (endpoint) |
| resMiss | output | 1 | No decoder claimed the address |

## Verification
A wrong stored window, way count, granule or skip shows up at the ports one edge after the next request that lands in the affected decoder. It appears as a wrong resPort, a wrong resAddr or a false miss. The bench therefore walks addresses across granule and window boundaries, right after each programming change. A stuck or wrongly cleared commit bit, and a priority mistake, appear the same way on the first request into the overlapping or freshly uncommitted window. Handshake faults show within a cycle, because reqReady and the held result are compared on every clock.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [2:0] {
    FLD_BASE  = 3'd0,
    FLD_SIZE  = 3'd1,
    FLD_CTRL  = 3'd2,
    FLD_TGT   = 3'd3,
    FLD_DBASE = 3'd4
  } cfg_field_e;

  // control word bit positions as written on cfgData
  localparam int CTL_WAYS_LSB  = 0;
  localparam int CTL_GRAN_BIT  = 2;
  localparam int CTL_SKIP_LSB  = 3;
  localparam int CTL_EP_BIT    = 5;
  localparam int CTL_COMMIT_BIT = 8;

  typedef struct packed {
    logic       commit;
    logic       ep;
    logic [1:0] skip;
    logic       gran8k;
    logic [1:0] waysLog2;
  } dec_ctl_t;

  typedef struct packed {
    logic cfgLoad;
    logic cfgUncommit;
    logic resLoad;
    logic resDrop;
  } ilv_strobe_t;
endpackage

// File: rtl/ilv_slot.sv
module ilv_slot
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 2,
  parameter int NUM_TGT   = 4,
  parameter int GRAN_LOG2 = 12
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-1:0]         base,
  input  logic [ADDR_W-1:0]         size,
  input  dec_ctl_t                  ctl,
  input  logic [NUM_TGT*PORT_W-1:0] tgtList,
  input  logic [ADDR_W-1:0]         devBase,
  output logic                      hit,
  output logic                      isEp,
  output logic [PORT_W-1:0]         port,
  output logic [ADDR_W-1:0]         devAddr
);
  localparam int SH_W   = $clog2(ADDR_W) + 2;
  localparam int TIDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] selWord;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] upper;
  logic [SH_W-1:0]   gShift;
  logic [SH_W-1:0]   selShift;
  logic [SH_W-1:0]   dropShift;
  logic [TIDX_W-1:0] wayMask;
  logic [TIDX_W-1:0] way;

  always_comb begin
    offset    = addr - base;
    hit       = ctl.commit && (addr >= base) && (offset < size);
    isEp      = ctl.ep;
    gShift    = SH_W'(GRAN_LOG2) + SH_W'(ctl.gran8k);
    selShift  = gShift + SH_W'(ctl.skip);
    dropShift = selShift + SH_W'(ctl.waysLog2);
    wayMask   = TIDX_W'((1 << ctl.waysLog2) - 1);
    selWord   = addr >> selShift;
    way       = selWord[TIDX_W-1:0] & wayMask;
    port      = tgtList[way*PORT_W +: PORT_W];
    lowMask   = (ADDR_W'(1) << gShift) - ADDR_W'(1);
    upper     = (offset >> dropShift) << gShift;
    devAddr   = devBase + (upper | (offset & lowMask));
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int NUM_DEC   = 4,
  parameter int DEC_IDX_W = 2
) (
  input  logic                 reqValid,
  input  logic                 resValid,
  input  logic                 resReady,
  input  logic                 cfgWrEn,
  input  logic [DEC_IDX_W-1:0] cfgDecSel,
  input  logic [2:0]           cfgField,
  input  logic                 cfgCommitBit,
  input  logic [NUM_DEC-1:0]   commitVec,
  output logic                 reqReady,
  output ilv_strobe_t          strobe
);
  logic selCommitted;
  logic accept;

  always_comb begin
    selCommitted = 1'b0;
    for (int i = 0; i < NUM_DEC; i++)
      if (cfgDecSel == DEC_IDX_W'(i)) selCommitted = commitVec[i];

    reqReady = !resValid || resReady;
    accept   = reqValid && reqReady;

    strobe.resLoad     = accept;
    strobe.resDrop     = resValid && resReady && !accept;
    strobe.cfgLoad     = cfgWrEn && !selCommitted;
    strobe.cfgUncommit = cfgWrEn && selCommitted &&
                         (cfgField == FLD_CTRL) && !cfgCommitBit;
  end
endmodule

// File: rtl/ilv_dp.sv
module ilv_dp
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_DEC   = 4,
  parameter int DEC_IDX_W = 2,
  parameter int PORT_W    = 2,
  parameter int NUM_TGT   = 4,
  parameter int GRAN_LOG2 = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ilv_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DEC_IDX_W-1:0] cfgDecSel,
  input  logic [2:0]           cfgField,
  input  logic [ADDR_W-1:0]    cfgData,
  output logic [NUM_DEC-1:0]   commitVec,
  output logic                 resValid,
  output logic [PORT_W-1:0]    resPort,
  output logic [ADDR_W-1:0]    resAddr,
  output logic                 resMiss
);
  localparam int TGT_W = NUM_TGT * PORT_W;

  logic [ADDR_W-1:0] baseR  [NUM_DEC];
  logic [ADDR_W-1:0] sizeR  [NUM_DEC];
  logic [ADDR_W-1:0] dbaseR [NUM_DEC];
  logic [TGT_W-1:0]  tgtR   [NUM_DEC];
  dec_ctl_t          ctlR   [NUM_DEC];

  logic [NUM_DEC-1:0] hitVec;
  logic [NUM_DEC-1:0] epVec;
  logic [PORT_W-1:0]  portVec [NUM_DEC];
  logic [ADDR_W-1:0]  devVec  [NUM_DEC];

  dec_ctl_t newCtl;
  assign newCtl = '{commit:   cfgData[CTL_COMMIT_BIT],
                    ep:       cfgData[CTL_EP_BIT],
                    skip:     cfgData[CTL_SKIP_LSB +: 2],
                    gran8k:   cfgData[CTL_GRAN_BIT],
                    waysLog2: cfgData[CTL_WAYS_LSB +: 2]};

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    always_ff @(posedge clk) begin
      if (rst) begin
        baseR[g]  <= '0;
        sizeR[g]  <= '0;
        dbaseR[g] <= '0;
        tgtR[g]   <= '0;
        ctlR[g]   <= '0;
      end else if (cfgDecSel == DEC_IDX_W'(g)) begin
        if (strobe.cfgLoad) begin
          case (cfgField)
            FLD_BASE:  baseR[g]  <= cfgData;
            FLD_SIZE:  sizeR[g]  <= cfgData;
            FLD_CTRL:  ctlR[g]   <= newCtl;
            FLD_TGT:   tgtR[g]   <= cfgData[TGT_W-1:0];
            FLD_DBASE: dbaseR[g] <= cfgData;
            default: ;
          endcase
        end else if (strobe.cfgUncommit) begin
          ctlR[g].commit <= 1'b0;
        end
      end
    end

    assign commitVec[g] = ctlR[g].commit;

    ilv_slot #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .NUM_TGT(NUM_TGT), .GRAN_LOG2(GRAN_LOG2)
    ) slot_i (
      .addr(reqAddr), .base(baseR[g]), .size(sizeR[g]), .ctl(ctlR[g]),
      .tgtList(tgtR[g]), .devBase(dbaseR[g]),
      .hit(hitVec[g]), .isEp(epVec[g]), .port(portVec[g]), .devAddr(devVec[g])
    );
  end

  logic              found;
  logic [PORT_W-1:0] selPort;
  logic [ADDR_W-1:0] selAddr;

  // walk from the top so the lowest index overrides
  always_comb begin
    found   = 1'b0;
    selPort = '0;
    selAddr = '0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        found   = 1'b1;
        selPort = epVec[i] ? '0 : portVec[i];
        selAddr = epVec[i] ? devVec[i] : reqAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resPort  <= '0;
      resAddr  <= '0;
      resMiss  <= 1'b0;
    end else if (strobe.resLoad) begin
      resValid <= 1'b1;
      resPort  <= selPort;
      resAddr  <= selAddr;
      resMiss  <= !found;
    end else if (strobe.resDrop) begin
      resValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ilv_addr_decoder.sv
module ilv_addr_decoder
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_DEC   = 4,
  parameter int PORT_W    = 2,
  parameter int NUM_TGT   = 4,
  parameter int GRAN_LOG2 = 12,
  localparam int DEC_IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 cfgWrEn,
  input  logic [DEC_IDX_W-1:0] cfgDecSel,
  input  logic [2:0]           cfgField,
  input  logic [ADDR_W-1:0]    cfgData,
  output logic                 resValid,
  input  logic                 resReady,
  output logic [PORT_W-1:0]    resPort,
  output logic [ADDR_W-1:0]    resAddr,
  output logic                 resMiss
);
  ilv_strobe_t        strobe;
  logic [NUM_DEC-1:0] commitVec;

  ilv_ctrl #(.NUM_DEC(NUM_DEC), .DEC_IDX_W(DEC_IDX_W)) ctrl_i (
    .reqValid(reqValid), .resValid(resValid), .resReady(resReady),
    .cfgWrEn(cfgWrEn), .cfgDecSel(cfgDecSel), .cfgField(cfgField),
    .cfgCommitBit(cfgData[CTL_COMMIT_BIT]), .commitVec(commitVec),
    .reqReady(reqReady), .strobe(strobe)
  );

  ilv_dp #(
    .ADDR_W(ADDR_W), .NUM_DEC(NUM_DEC), .DEC_IDX_W(DEC_IDX_W),
    .PORT_W(PORT_W), .NUM_TGT(NUM_TGT), .GRAN_LOG2(GRAN_LOG2)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .cfgDecSel(cfgDecSel), .cfgField(cfgField), .cfgData(cfgData),
    .commitVec(commitVec), .resValid(resValid), .resPort(resPort),
    .resAddr(resAddr), .resMiss(resMiss)
  );
endmodule

// File: rtl/ilv_addr_decoder_chk.sv
module ilv_addr_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              resValid,
  input logic              resReady,
  input logic [PORT_W-1:0] resPort,
  input logic [ADDR_W-1:0] resAddr,
  input logic              resMiss
);
  a_r10_ready_low: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |-> !reqReady);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> (resValid && $stable(resPort) &&
                                 $stable(resAddr) && $stable(resMiss)));

  a_r10_accept_next: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> resValid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!(reqValid && reqReady) && (!resValid || resReady)) |=> !resValid);

  a_r11_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (resValid && resMiss) |-> (resPort == '0 && resAddr == '0));
endmodule

bind ilv_addr_decoder ilv_addr_decoder_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .resValid(resValid), .resReady(resReady), .resPort(resPort),
  .resAddr(resAddr), .resMiss(resMiss)
);

// File: tb/ilv_addr_decoder_tb_top.sv
module ilv_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqReady, cfgWrEn, resValid, resReady, resMiss;
  logic [31:0] reqAddr, cfgData, resAddr;
  logic [1:0]  cfgDecSel, resPort;
  logic [2:0]  cfgField;

  always #4 clk = ~clk;

  ilv_addr_decoder dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .cfgWrEn(cfgWrEn), .cfgDecSel(cfgDecSel),
    .cfgField(cfgField), .cfgData(cfgData), .resValid(resValid),
    .resReady(resReady), .resPort(resPort), .resAddr(resAddr), .resMiss(resMiss)
  );

  int    nTests = 0;
  int    nFails = 0;
  string curTag = "R1";

  longint mBase[4], mSize[4], mDbase[4], mTgt[4], mCtl[4];
  bit     mValid, mMiss;
  longint mPort, mAddr;

  task automatic check(string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curTag, what, act, exp);
    end
  endtask

  function automatic void lookup(input longint a, output bit hitAny,
                                 output longint p, output longint o);
    hitAny = 0; p = 0; o = 0;
    for (int d = 0; d < 4; d++) begin
      longint g, sk, w, off;
      if (hitAny) continue;
      if (((mCtl[d] / 256) % 2) == 0) continue;
      if (a < mBase[d] || a >= mBase[d] + mSize[d]) continue;
      hitAny = 1;
      w  = mCtl[d] % 4;
      g  = 4096 * (1 + ((mCtl[d] / 4) % 2));
      sk = (mCtl[d] / 8) % 4;
      if (((mCtl[d] / 32) % 2) == 1) begin
        off = a - mBase[d];
        o = (mDbase[d] + (off / (g * (2 ** (sk + w)))) * g + (off % g)) % 64'h1_0000_0000;
        p = 0;
      end else begin
        p = (mTgt[d] / (4 ** ((a / (g * (2 ** sk))) % (2 ** w)))) % 4;
        o = a;
      end
    end
  endfunction

  task automatic step();
    bit     h;
    longint p, o;
    if (reqValid && (!mValid || resReady)) begin
      lookup(reqAddr, h, p, o);
      mValid = 1; mMiss = !h; mPort = p; mAddr = o;
    end else if (mValid && resReady) begin
      mValid = 0;
    end
    if (cfgWrEn) begin
      if (((mCtl[cfgDecSel] / 256) % 2) == 0) begin
        case (cfgField)
          3'd0: mBase[cfgDecSel]  = cfgData;
          3'd1: mSize[cfgDecSel]  = cfgData;
          3'd2: mCtl[cfgDecSel]   = cfgData & 32'h13F;
          3'd3: mTgt[cfgDecSel]   = cfgData & 32'hFF;
          3'd4: mDbase[cfgDecSel] = cfgData;
          default: ;
        endcase
      end else if (cfgField == 3'd2 && cfgData[8] == 1'b0) begin
        mCtl[cfgDecSel] = mCtl[cfgDecSel] - 256;
      end
    end
    @(posedge clk);
    #1;
    check("resValid", resValid, mValid);
    check("reqReady", reqReady, (!mValid || resReady));
    if (mValid) begin
      check("resMiss", resMiss, mMiss);
      check("resPort", resPort, mPort);
      check("resAddr", resAddr, mAddr);
    end
  endtask

  task automatic cfgWrite(int d, int f, longint v);
    cfgWrEn = 1; cfgDecSel = 2'(d); cfgField = 3'(f); cfgData = 32'(v);
    step();
    cfgWrEn = 0;
  endtask

  task automatic request(longint a);
    reqValid = 1; reqAddr = 32'(a); resReady = 1;
    step();
    reqValid = 0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    rst = 1; reqValid = 0; reqAddr = 0; cfgWrEn = 0; cfgDecSel = 0;
    cfgField = 0; cfgData = 0; resReady = 0;
    for (int d = 0; d < 4; d++) begin
      mBase[d] = 0; mSize[d] = 0; mDbase[d] = 0; mTgt[d] = 0; mCtl[d] = 0;
    end
    mValid = 0; mMiss = 0; mPort = 0; mAddr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: idle after reset
    curTag = "R1";
    check("resValid", resValid, 0);
    check("reqReady", reqReady, 1);
    step();
    request(64'h1000_0040);

    // R8: uncommitted decoder never claims
    curTag = "R8";
    cfgWrite(0, 0, 64'h1000_0000);
    cfgWrite(0, 1, 64'h1000_0000);
    cfgWrite(0, 3, 64'h02);
    cfgWrite(0, 2, 64'h000);
    request(64'h1000_0040);

    // R3: single target pass-through
    curTag = "R3";
    cfgWrite(0, 2, 64'h100);
    request(64'h1000_0040);
    request(64'h1234_5678);

    // R2: window edges
    curTag = "R2";
    request(64'h0FFF_FFFF);
    request(64'h1000_0000);
    request(64'h1FFF_FFFF);
    request(64'h2000_0000);

    // R12: lookup in the write cycle sees old settings
    curTag = "R12";
    reqValid = 1; reqAddr = 32'h2000_1000; resReady = 1;
    cfgWrEn = 1; cfgDecSel = 1; cfgField = 0; cfgData = 32'h2000_0000;
    step();
    cfgWrEn = 0; reqValid = 0;
    step();

    // R4: 2-way 4 KiB and 4-way 8 KiB
    curTag = "R4";
    cfgWrite(1, 1, 64'h0010_0000);
    cfgWrite(1, 3, 64'h0D);
    cfgWrite(1, 2, 64'h101);
    for (int k = 0; k < 5; k++) request(64'h2000_0000 + k * 64'h1000);
    request(64'h2000_3FFF);
    cfgWrite(2, 0, 64'h3000_0000);
    cfgWrite(2, 1, 64'h0010_0000);
    cfgWrite(2, 3, 64'h1B);
    cfgWrite(2, 2, 64'h106);
    for (int k = 0; k < 6; k++) request(64'h3000_0000 + k * 64'h2000);
    request(64'h3000_1FFF);
    request(64'h3000_3FFF);

    // R9: writes to committed decoder ignored
    curTag = "R9";
    cfgWrite(1, 0, 64'h5000_0000);
    cfgWrite(1, 3, 64'h00);
    cfgWrite(1, 2, 64'h105);
    request(64'h2000_1000);
    request(64'h5000_0000);

    // R5: cascaded interleave with one skipped bit
    curTag = "R5";
    cfgWrite(1, 2, 64'h000);
    cfgWrite(1, 2, 64'h109);
    for (int k = 0; k < 8; k++) request(64'h2000_0000 + k * 64'h1000);

    // R6: endpoint translation
    curTag = "R6";
    cfgWrite(3, 0, 64'h4000_0000);
    cfgWrite(3, 1, 64'h0100_0000);
    cfgWrite(3, 4, 64'h0800_0000);
    cfgWrite(3, 3, 64'hFF);
    cfgWrite(3, 2, 64'h129);
    request(64'h4000_0010);
    request(64'h4000_1010);
    request(64'h4000_4010);
    request(64'h4000_5ABC);
    request(64'h40FF_FFFF);

    // R7: lowest index wins on overlap
    curTag = "R7";
    cfgWrite(2, 2, 64'h000);
    cfgWrite(2, 0, 64'h1000_0000);
    cfgWrite(2, 1, 64'h0000_1000);
    cfgWrite(2, 2, 64'h100);
    request(64'h1000_0000);
    cfgWrite(0, 2, 64'h000);
    request(64'h1000_0000);

    // R11: miss output values
    curTag = "R11";
    request(64'h1000_1000);
    request(64'hF000_0000);

    // R10: backpressure and back-to-back
    curTag = "R10";
    reqValid = 1; reqAddr = 32'h2000_2000; resReady = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      reqAddr = reqAddr + 32'h1000;
    end
    resReady = 1;
    for (int k = 0; k < 6; k++) begin
      step();
      reqAddr = 32'h4000_0000 + 32'(k) * 32'h3000;
    end
    reqValid = 0;
    step();
    resReady = 0;
    step();

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule